// File: doc/BRIEF.md
# Dual-Bank Color Matrix Transform

This block multiplies every incoming RGB pixel by a 3x4 color matrix. Each output component is a weighted sum of the three input components plus a per-row offset. The result is rounded and then saturated. Software keeps two complete coefficient sets, called bank A and bank B. It can rewrite the idle bank while the other bank is in use, then swap banks at a frame boundary. Pixels do not have to stop while it does so.

Coefficients are 16-bit signed values in fixed point, with 2 integer bits and 13 fractional bits, so 8192 means 1.0. The offset column is a signed integer counted in output LSBs. A programmed mode field selects bypass, bank A or bank B. That choice takes effect only on a frame-start strobe, and a read-only field shows the mode that is currently applied.

Each pixel takes the mode and coefficients in force when it is accepted, and keeps them as it moves through the pipeline. The pixel stream uses valid/ready on both sides. The output holds its value under back-pressure. The input is ready whenever the output stage is empty or is being drained in that cycle.

Top module: `gamut_matrix_xform`

## Requirements
- R1: After reset, out_valid is 0 and every register reads 0: the mode word, the current-mode field and all twelve coefficient words.
- R2: Register map. Address 0 is the mode word, with the programmed mode in bits [1:0] (read/write) and the current mode in bits [9:8] (read only). Bank A word k is at address 8+k and bank B word k is at address 16+k, for k = 0..5. Word k holds coefficient 2k in bits [15:0] and coefficient 2k+1 in bits [31:16], where coefficient index = row*4 + column and column 3 is the offset. Words read back exactly as written, and unmapped addresses read 0.
- R3: A write to one bank never changes any word of the other bank.
- R4: The current-mode field takes the programmed mode only at a clock edge where frame_start is 1. At every other edge it holds its value.
- R5: Mode decode: 0 and 3 select bypass, 1 selects bank A and 2 selects bank B.
- R6: With a bank active, output component r = floor((sum over c of C[r][c]*x[c] + C[r][3]*8192 + 4096) / 8192). This is round to nearest, with exact halves rounded toward positive.
- R7: Results above 32767 are clamped to 32767, and results below -32768 are clamped to -32768.
- R8: In bypass mode the output components equal the input components exactly. The latency is the same as in the matrix path.
- R9: A pixel accepted at edge t is presented with out_valid = 1 after edge t+2, provided out_ready was high. A full stream runs at one pixel per cycle.
- R10: While out_valid is 1 and out_ready is 0, the output data holds and in_ready is 0. When out_valid is 0, in_ready is 1. No pixel is lost or repeated.
- R11: Pixels already accepted when frame_start changes the mode still complete with the mode they were accepted under.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that loads the programmed mode into the current mode |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | ADDR_W (5) | Register address for both write and read |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when both valid and ready are 1 |
| in_pix | input | 3*COMP_W (48) | Signed components: red [15:0], green [31:16], blue [47:32] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pix | output | 3*COMP_W (48) | Transformed components, packed like in_pix |

## Verification
A wrong current mode shows up on the mode word at once. On the pixel side, it first appears three edges after the next accepted pixel, as every component of that pixel going wrong together. A corrupted coefficient word affects only the one row that uses it, so the bench sweeps all three input components over extreme, signed and small values. Each row is then compared with an arithmetic model for every combination. A broken stall path shows as output data changing, or an extra or missing pixel, during the deliberately held-off cycles.

// File: rtl/gmx_pkg.sv
package gmx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    GM_BYPASS = 2'd0,
    GM_BANK_A = 2'd1,
    GM_BANK_B = 2'd2,
    GM_RSVD   = 2'd3
  } gm_mode_e;

  localparam int GM_ROWS     = 3;
  localparam int GM_COLS     = 4;
  localparam int GM_NCOEF    = GM_ROWS * GM_COLS;
  localparam int GM_CUR_LSB  = 8;
endpackage

// File: rtl/gmx_coef_bank.sv
module gmx_coef_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int COEF_W = 16,
  parameter int NCOEF  = 12,
  parameter int BASE   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NCOEF*COEF_W-1:0]   coef_flat,
  output logic [DATA_W-1:0]         rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NWORD = NCOEF / 2;

  logic [COEF_W-1:0] lo_q [NWORD];
  logic [COEF_W-1:0] hi_q [NWORD];
  logic [NWORD-1:0]  sel;

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    assign sel[k] = (addr == ADDR_W'(BASE + k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[k] <= '0;
        hi_q[k] <= '0;
      end else if (wr_en && sel[k]) begin
        lo_q[k] <= wdata[COEF_W-1:0];
        hi_q[k] <= wdata[2*COEF_W-1:COEF_W];
      end
    end

    assign coef_flat[(2*k)*COEF_W   +: COEF_W] = lo_q[k];
    assign coef_flat[(2*k+1)*COEF_W +: COEF_W] = hi_q[k];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NWORD; k++) begin
      if (sel[k]) rdata = DATA_W'({hi_q[k], lo_q[k]});
    end
  end
endmodule

// File: rtl/gmx_mode_ctl.sv
module gmx_mode_ctl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wmode,
  input  logic              frame_start,
  output logic [1:0]        prog_mode,
  output logic [1:0]        cur_mode,
  output logic [DATA_W-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;
  import gmx_pkg::*;

  logic hit;
  assign hit = (addr == ADDR_W'(ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_mode <= GM_BYPASS;
      cur_mode  <= GM_BYPASS;
    end else begin
      if (wr_en && hit) prog_mode <= wmode;
      if (frame_start)  cur_mode  <= prog_mode;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[1:0]                       = prog_mode;
      rdata[GM_CUR_LSB+1:GM_CUR_LSB]   = cur_mode;
    end
  end
endmodule

// File: rtl/gmx_pipe.sv
module gmx_pipe #(
  parameter int COMP_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13,
  parameter int NCOEF  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [3*COMP_W-1:0]      in_pix,
  input  logic [NCOEF*COEF_W-1:0]  coef_flat,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [3*COMP_W-1:0]      out_pix
);
  timeunit 1ns;
  timeprecision 1ps;
  import gmx_pkg::*;

  localparam int PROD_W = COMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] HI  = ACC_W'((64'sd1 <<< (COMP_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] LO  = ACC_W'(-(64'sd1 <<< (COMP_W - 1)));

  logic adv;
  logic v1, v2, v3;

  logic signed [COMP_W-1:0] x1 [GM_ROWS];
  logic signed [COEF_W-1:0] k1 [NCOEF];
  logic signed [PROD_W-1:0] p2 [GM_ROWS*GM_ROWS];
  logic signed [COEF_W-1:0] o2 [GM_ROWS];
  logic signed [COMP_W-1:0] y3 [GM_ROWS];
  logic signed [ACC_W-1:0]  acc [GM_ROWS];
  logic signed [ACC_W-1:0]  shf [GM_ROWS];
  logic signed [COMP_W-1:0] sat [GM_ROWS];

  // Global stall: every stage moves when the last stage is empty or draining.
  assign adv       = !v3 || out_ready;
  assign in_ready  = adv;
  assign out_valid = v3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  // Stage 1: capture pixel together with the coefficient set in force.
  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      for (int c = 0; c < GM_ROWS; c++) x1[c] <= in_pix[c*COMP_W +: COMP_W];
      for (int i = 0; i < NCOEF; i++)   k1[i] <= coef_flat[i*COEF_W +: COEF_W];
    end
  end

  // Stage 2: nine products and the three offsets.
  always_ff @(posedge clk) begin
    if (adv && v1) begin
      for (int r = 0; r < GM_ROWS; r++) begin
        for (int c = 0; c < GM_ROWS; c++) begin
          p2[r*GM_ROWS+c] <= PROD_W'(x1[c]) * PROD_W'(k1[r*GM_COLS+c]);
        end
        o2[r] <= k1[r*GM_COLS+GM_ROWS];
      end
    end
  end

  // Stage 3 arithmetic: sum, offset, round, saturate.
  always_comb begin
    for (int r = 0; r < GM_ROWS; r++) begin
      acc[r] = ACC_W'(p2[r*GM_ROWS]) + ACC_W'(p2[r*GM_ROWS+1]) + ACC_W'(p2[r*GM_ROWS+2])
             + (ACC_W'(o2[r]) <<< FRAC_W) + RND;
      shf[r] = acc[r] >>> FRAC_W;
      if (shf[r] > HI)      sat[r] = HI[COMP_W-1:0];
      else if (shf[r] < LO) sat[r] = LO[COMP_W-1:0];
      else                  sat[r] = shf[r][COMP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (adv && v2) begin
      for (int r = 0; r < GM_ROWS; r++) y3[r] <= sat[r];
    end
  end

  for (genvar c = 0; c < GM_ROWS; c++) begin : g_out
    assign out_pix[c*COMP_W +: COMP_W] = y3[c];
  end
endmodule

// File: rtl/gamut_matrix_xform.sv
module gamut_matrix_xform #(
  parameter int COMP_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 13,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int MODE_AD = 0,
  parameter int BANKA_AD = 8,
  parameter int BANKB_AD = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3*COMP_W-1:0]  in_pix,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [3*COMP_W-1:0]  out_pix
);
  timeunit 1ns;
  timeprecision 1ps;
  import gmx_pkg::*;

  localparam int CF_W = GM_NCOEF * COEF_W;
  localparam logic [COEF_W-1:0] ONE = COEF_W'(1 << FRAC_W);

  logic [CF_W-1:0]   coef_a, coef_b, coef_id, coef_use;
  logic [DATA_W-1:0] rd_a, rd_b, rd_m;
  logic [1:0]        prog_mode, cur_mode;

  gmx_mode_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR(MODE_AD)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wmode(reg_wdata[1:0]), .frame_start(frame_start),
    .prog_mode(prog_mode), .cur_mode(cur_mode), .rdata(rd_m)
  );

  gmx_coef_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_W(COEF_W),
                  .NCOEF(GM_NCOEF), .BASE(BANKA_AD)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .coef_flat(coef_a), .rdata(rd_a)
  );

  gmx_coef_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_W(COEF_W),
                  .NCOEF(GM_NCOEF), .BASE(BANKB_AD)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .coef_flat(coef_b), .rdata(rd_b)
  );

  assign reg_rdata = rd_m | rd_a | rd_b;

  // Bypass runs through the same datapath with an identity matrix.
  for (genvar i = 0; i < GM_NCOEF; i++) begin : g_ident
    assign coef_id[i*COEF_W +: COEF_W] = ((i % GM_COLS) == (i / GM_COLS)) ? ONE : '0;
  end

  always_comb begin
    case (gm_mode_e'(cur_mode))
      GM_BANK_A: coef_use = coef_a;
      GM_BANK_B: coef_use = coef_b;
      default:   coef_use = coef_id;
    endcase
  end

  gmx_pipe #(.COMP_W(COMP_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .NCOEF(GM_NCOEF)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .coef_flat(coef_use), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );
endmodule

// File: rtl/gmx_checks.sv
module gmx_checks #(
  parameter int PIX_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             frame_start,
  input logic [1:0]       prog_mode,
  input logic [1:0]       cur_mode
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R10
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R10
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_mode)); // R4
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cur_mode == $past(prog_mode)); // R4
endmodule

bind gamut_matrix_xform gmx_checks #(.PIX_W(3*COMP_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .frame_start(frame_start),
  .prog_mode(prog_mode), .cur_mode(cur_mode)
);

// File: tb/sim_gamut_matrix_xform.sv
module sim_gamut_matrix_xform;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [47:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [47:0] out_pix;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int ca [12] = '{12288, -2048, 1024, 100, -4096, 8192, 2731, -250, 700, -300, 9000, 0};
  int cb [12] = '{4096, 0, 0, 0, 32767, 0, 0, 7, -32768, 0, 0, -5};
  int vals [7] = '{-32768, -1000, -1, 0, 1, 777, 32767};
  int act_mode = 0;
  logic [47:0] qin [$];
  logic [47:0] qexp [$];
  logic [47:0] last_out;

  always #2.5 clk = ~clk;

  gamut_matrix_xform u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int m, int x0, int x1, int x2, int r);
    longint acc;
    int k [12];
    if (m == 1) k = ca;
    else if (m == 2) k = cb;
    else return (r == 0) ? x0 : (r == 1) ? x1 : x2;
    acc = longint'(k[r*4])*x0 + longint'(k[r*4+1])*x1 + longint'(k[r*4+2])*x2
        + longint'(k[r*4+3])*8192 + 4096;
    acc = acc >>> 13;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic logic [47:0] pack(int a, int b, int c);
    return {16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic push(int a, int b, int c);
    qin.push_back(pack(a, b, c));
    qexp.push_back(pack(model(act_mode, a, b, c, 0), model(act_mode, a, b, c, 1),
                        model(act_mode, a, b, c, 2)));
  endtask

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 5'(addr); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(addr);
    #1 d = reg_rdata;
  endtask

  task automatic strobe(int m);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    act_mode = m;
  endtask

  // pattern: 0 always ready, 1 two of three, 2 two of five, 3 held off for 8 cycles
  task automatic run_stream(input string req, input int pat, input int strobe_cyc);
    int cyc = 0;
    bit in_fire, out_fire, stalled = 0;
    logic [47:0] cap, held;
    while (qexp.size() > 0 && cyc < 20000) begin
      @(negedge clk);
      in_valid = (qin.size() > 0);
      in_pix = (qin.size() > 0) ? qin[0] : '0;
      case (pat)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 2;
        2: out_ready = (cyc % 5) < 2;
        default: out_ready = (cyc >= 8);
      endcase
      frame_start = (cyc == strobe_cyc);
      #1;
      if (stalled) chk({req, " R10 hold"}, longint'(out_pix), longint'(held));
      stalled = out_valid && !out_ready;
      if (stalled) begin
        held = out_pix;
        chk({req, " R10 in_ready"}, longint'(in_ready), 0);
      end
      in_fire = in_valid && in_ready;
      out_fire = out_valid && out_ready;
      cap = out_pix;
      @(posedge clk);
      if (in_fire) void'(qin.pop_front());
      if (out_fire) begin
        chk(req, longint'(cap), longint'(qexp.pop_front()));
        last_out = cap;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
    chk({req, " drained"}, qexp.size(), 0);
  endtask

  task automatic latency(input string req, int a, int b, int c);
    logic [47:0] e;
    e = pack(model(act_mode, a, b, c, 0), model(act_mode, a, b, c, 1), model(act_mode, a, b, c, 2));
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_pix = pack(a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R9 t+0"}, longint'(out_valid), 0);
    @(negedge clk);
    chk({req, " R9 t+1"}, longint'(out_valid), 0);
    @(negedge clk);
    chk({req, " R9 t+2"}, longint'(out_valid), 1);
    chk({req, " R9 data"}, longint'(out_pix), longint'(e));
    @(negedge clk);
    chk({req, " R9 single"}, longint'(out_valid), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R10 ready when empty", longint'(in_ready), 1);
    rd(0, d);  chk("R1 mode word", longint'(d), 0);
    rd(8, d);  chk("R1 bank A word", longint'(d), 0);
    rd(21, d); chk("R1 bank B word", longint'(d), 0);
    // R2 program and read back
    for (int k = 0; k < 6; k++) wr(8 + k, {16'(ca[2*k+1]), 16'(ca[2*k])});
    for (int k = 0; k < 6; k++) wr(16 + k, {16'(cb[2*k+1]), 16'(cb[2*k])});
    for (int k = 0; k < 6; k++) begin
      rd(8 + k, d);  chk("R3 bank A after B writes", longint'(d), longint'({16'(ca[2*k+1]), 16'(ca[2*k])}));
      rd(16 + k, d); chk("R2 bank B readback", longint'(d), longint'({16'(cb[2*k+1]), 16'(cb[2*k])}));
    end
    rd(6, d); chk("R2 unmapped", longint'(d), 0);
    // R4 programmed mode not applied until strobe
    wr(0, 32'h1);
    rd(0, d); chk("R4 prog=1 cur=0", longint'(d), 32'h001);
    // R11 pixels in flight keep bypass across a strobe while stalled
    push(123, -456, 789); push(-32768, 32767, 0); push(5, 6, 7);
    run_stream("R11 R8 in-flight", 3, 5);
    act_mode = 1;
    rd(0, d); chk("R4 cur follows strobe", longint'(d), 32'h101);
    // R6 R7 bank A sweep
    foreach (vals[i]) foreach (vals[j]) foreach (vals[k]) push(vals[i], vals[j], vals[k]);
    run_stream("R6 R7 bank A sweep", 1, -1);
    latency("bank A", 300, -200, 100);
    // R5 bank B
    wr(0, 32'h2);
    rd(0, d); chk("R4 hold without strobe", longint'(d), 32'h102);
    strobe(2);
    push(1, 0, 0);  run_stream("R6", 0, -1); chk("R6 half up +0.5", longint'($signed(last_out[15:0])), 1);
    push(-1, 0, 0); run_stream("R6", 0, -1); chk("R6 half up -0.5", longint'($signed(last_out[15:0])), 0);
    push(-3, 0, 0); run_stream("R6", 0, -1); chk("R6 half up -1.5", longint'($signed(last_out[15:0])), -1);
    push(20000, 0, 0); run_stream("R7", 0, -1);
    chk("R7 clamp high", longint'($signed(last_out[31:16])), 32767);
    chk("R7 clamp low", longint'($signed(last_out[47:32])), -32768);
    foreach (vals[i]) foreach (vals[j]) foreach (vals[k]) push(vals[i], vals[j], vals[k]);
    run_stream("R5 bank B sweep", 2, -1);
    // R5 R8 mode 3 is bypass
    wr(0, 32'h3); strobe(3);
    rd(0, d); chk("R4 mode 3 current", longint'(d), 32'h303);
    foreach (vals[i]) foreach (vals[j]) foreach (vals[k]) push(vals[i], vals[j], vals[k]);
    run_stream("R5 R8 mode3 bypass", 0, -1);
    wr(0, 32'h0); strobe(0);
    latency("R8 bypass", -32768, 32767, -7);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule